// File: doc/BRIEF.md
# One-Shot Down-Counter Channel

This block is a single timer channel that produces one output pulse per run. Software loads a 16-bit count value, then sets a run bit. The output pin goes high at the next clock edge. While the run bit is set, each pulse on the prescaled count-enable input lowers the counter by one. When the counter is already at zero and another count-enable pulse arrives, the channel underflows. At that point the run bit drops, the output pulse ends, and a sticky done flag is raised. The flag can drive a level interrupt request.

Software has no direct way to drop the run bit. To abort a run, it loads zero into the counter. The channel then keeps running until the next count-enable pulse. That pulse causes an underflow, and the flag is set for an aborted run just as it is for a run that completes normally. A small register port covers all access: one write strobe, a 2-bit address, 16 bits of write data, and registered read data that appears one clock after the address.

Top module: `odc_top`

## Requirements
- R1: Address 0 holds the counter. A write stores the write data. The counter drops by exactly one per count-enable pulse only while the run bit (address 1, bit 0) is 1, and it holds its value otherwise.
- R2: Writing 1 to bit 0 of address 1 sets the run bit. Writing 0 to that bit leaves the run bit unchanged. Bit 1 of address 1 is the interrupt enable, and it takes whatever value is written.
- R3: A counter write in the same cycle as a count-enable pulse wins. The counter takes the written value and no decrement or underflow happens in that cycle.
- R4: An underflow is a count-enable pulse while the run bit is 1 and the counter is 0. It clears the run bit and sets the done flag (address 2, bit 0), and the counter stays at 0.
- R5: Writing 0 to the counter while running does not stop the channel. The run bit stays 1 until the next count-enable pulse, which underflows the channel.
- R6: Writing 1 to bit 0 of address 2 clears the done flag, and writing 0 there has no effect. A clear in the same cycle as an underflow wins, so the flag stays 0.
- R7: The pulse output is high starting with the edge that sets the run bit and falls at the edge where an underflow clears it.
- R8: The interrupt output is high exactly when both the done flag and the interrupt enable are 1, and it changes at the same edge as they do.
- R9: After reset the counter, run bit, flag, enable, read data and both outputs are 0.
- R10: A run-bit set in the same cycle as an underflow leaves the run bit at 1, so the channel restarts.
- R11: The read data shows the value at the presented address one clock later. Address 1 reads as {enable, run}, address 2 reads as {flag}, and address 3 reads as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_tick | input | 1 | Prescaled count-enable pulse |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Registered read data |
| pulse_out | output | 1 | One-shot output pulse |
| irq | output | 1 | Level interrupt request |

## Verification
A counter that holds a wrong value shows up on the read port one clock after address 0 is selected. Even without a read, it shifts the falling edge of the pulse output by one or more count-enable periods. A run bit or done flag in the wrong state shows on the pulse and interrupt pins at the very next edge. The bench therefore compares every output against a reference model on every cycle. Directed steps cover the same-cycle contentions: a counter write against a count pulse, a flag clear against an underflow, and a run-bit set against an underflow.

// File: rtl/odc_pkg.sv
package odc_pkg;
  localparam int ADDR_W = 2;
  localparam logic [ADDR_W-1:0] A_COUNT  = 2'd0;
  localparam logic [ADDR_W-1:0] A_CTRL   = 2'd1;
  localparam logic [ADDR_W-1:0] A_STATUS = 2'd2;
  localparam int CTRL_RUN_BIT  = 0;
  localparam int CTRL_IEN_BIT  = 1;
  localparam int STAT_DONE_BIT = 0;

  typedef struct packed {
    logic wr_count;
    logic set_run;
    logic wr_ctrl;
    logic ien_val;
    logic clr_done;
  } odc_strobe_t;
endpackage

// File: rtl/odc_regif.sv
module odc_regif
  import odc_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [CNT_W-1:0]  count,
  input  logic              run,
  input  logic              ien,
  input  logic              done,
  output odc_strobe_t       strb,
  output logic [DATA_W-1:0] rdata
);
  localparam int COPY_W = (CNT_W < DATA_W) ? CNT_W : DATA_W;

  always_comb begin
    strb          = '0;
    strb.wr_count = wr_en && (addr == A_COUNT);
    strb.wr_ctrl  = wr_en && (addr == A_CTRL);
    strb.set_run  = strb.wr_ctrl && wdata[CTRL_RUN_BIT];
    strb.ien_val  = wdata[CTRL_IEN_BIT];
    strb.clr_done = wr_en && (addr == A_STATUS) && wdata[STAT_DONE_BIT];
  end

  logic [DATA_W-1:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    unique case (addr)
      A_COUNT:  rd_mux[COPY_W-1:0] = count[COPY_W-1:0];
      A_CTRL: begin
        rd_mux[CTRL_RUN_BIT] = run;
        rd_mux[CTRL_IEN_BIT] = ien;
      end
      A_STATUS: rd_mux[STAT_DONE_BIT] = done;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_mux;
  end

  // R11
  unused_addr_chk: assert property (@(posedge clk) disable iff (rst)
    (addr == 2'd3) |=> (rdata == '0));
endmodule

// File: rtl/odc_counter.sv
module odc_counter #(
  parameter int CNT_W  = 16,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_count,
  input  logic [DATA_W-1:0] wdata,
  input  logic              tick,
  input  logic              run,
  output logic [CNT_W-1:0]  count,
  output logic              underflow
);
  localparam int COPY_W = (CNT_W < DATA_W) ? CNT_W : DATA_W;
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic              at_zero;
  logic              dec;
  logic [CNT_W-1:0]  load_val;

  always_comb begin
    load_val = '0;
    load_val[COPY_W-1:0] = wdata[COPY_W-1:0];
  end

  assign at_zero   = (count == '0);
  assign dec       = run && tick && !wr_count && !at_zero;
  assign underflow = run && tick && !wr_count && at_zero;

  always_ff @(posedge clk) begin
    if (rst)           count <= '0;
    else if (wr_count) count <= load_val;
    else if (dec)      count <= count - ONE;
  end

  // R1
  cnt_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!wr_count && !(run && tick)) |=> $stable(count));
  // R1
  cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
    (!wr_count && run && tick && count != '0) |=> (count == $past(count) - ONE));
  // R3
  wr_prio_chk: assert property (@(posedge clk) disable iff (rst)
    wr_count |=> (count == $past(load_val)));
  // R4
  no_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (!wr_count && count == '0) |=> (count == '0));
endmodule

// File: rtl/odc_ctrl.sv
module odc_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic set_run,
  input  logic wr_ctrl,
  input  logic ien_val,
  input  logic clr_done,
  input  logic underflow,
  output logic run,
  output logic ien,
  output logic done,
  output logic pulse_out,
  output logic irq
);
  logic run_n, ien_n, done_n;

  always_comb begin
    run_n  = set_run ? 1'b1 : (underflow ? 1'b0 : run);
    ien_n  = wr_ctrl ? ien_val : ien;
    done_n = clr_done ? 1'b0 : (underflow ? 1'b1 : done);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run       <= 1'b0;
      ien       <= 1'b0;
      done      <= 1'b0;
      pulse_out <= 1'b0;
      irq       <= 1'b0;
    end else begin
      run       <= run_n;
      ien       <= ien_n;
      done      <= done_n;
      pulse_out <= run_n;
      irq       <= done_n && ien_n;
    end
  end

  // R2
  run_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (run && !underflow) |=> run);
  // R4
  uf_done_chk: assert property (@(posedge clk) disable iff (rst)
    (underflow && !clr_done) |=> done);
  // R6
  clr_wins_chk: assert property (@(posedge clk) disable iff (rst)
    clr_done |=> !done);
  // R7
  pulse_rise_chk: assert property (@(posedge clk) disable iff (rst)
    set_run |=> pulse_out);
  // R7
  pulse_fall_chk: assert property (@(posedge clk) disable iff (rst)
    (underflow && !set_run) |=> !pulse_out);
  // R8
  irq_src_chk: assert property (@(posedge clk) disable iff (rst)
    irq |-> (done && ien));
endmodule

// File: rtl/odc_top.sv
module odc_top
  import odc_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cnt_tick,
  input  logic              wr_en,
  input  logic [1:0]        addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              pulse_out,
  output logic              irq
);
  odc_strobe_t      strb;
  logic [CNT_W-1:0] count;
  logic             run, ien, done, underflow;

  odc_regif #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_regif (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .count(count), .run(run), .ien(ien), .done(done),
    .strb(strb), .rdata(rdata)
  );

  odc_counter #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_counter (
    .clk(clk), .rst(rst), .wr_count(strb.wr_count), .wdata(wdata),
    .tick(cnt_tick), .run(run), .count(count), .underflow(underflow)
  );

  odc_ctrl u_ctrl (
    .clk(clk), .rst(rst), .set_run(strb.set_run), .wr_ctrl(strb.wr_ctrl),
    .ien_val(strb.ien_val), .clr_done(strb.clr_done), .underflow(underflow),
    .run(run), .ien(ien), .done(done), .pulse_out(pulse_out), .irq(irq)
  );
endmodule

// File: tb/tb_odc_top.sv
`timescale 1ns/1ps
module tb_odc_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cnt_tick = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [15:0] wdata = 16'd0;
  logic [15:0] rdata;
  logic        pulse_out, irq;

  int checks = 0;
  int errors = 0;

  logic [15:0] m_cnt = 0;
  logic        m_run = 0, m_ien = 0, m_done = 0;
  logic [15:0] e_rdata = 0;

  always #2.5 clk = ~clk;

  odc_top dut (
    .clk(clk), .rst(rst), .cnt_tick(cnt_tick), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .pulse_out(pulse_out), .irq(irq)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] rd_model(input logic [1:0] a);
    case (a)
      2'd0:    return m_cnt;
      2'd1:    return {14'd0, m_ien, m_run};
      2'd2:    return {15'd0, m_done};
      default: return 16'd0;
    endcase
  endfunction

  // Drive at negedge, advance one edge, update model, compare at next negedge.
  task automatic step(input logic t, input logic w, input logic [1:0] a,
                      input logic [15:0] d, input string tag);
    logic wc, uf, setr, clr;
    cnt_tick = t; wr_en = w; addr = a; wdata = d;
    @(posedge clk);
    wc   = w && a == 2'd0;
    uf   = m_run && t && !wc && m_cnt == 16'd0;
    setr = w && a == 2'd1 && d[0];
    clr  = w && a == 2'd2 && d[0];
    e_rdata = rd_model(a);
    if (wc) m_cnt = d;
    else if (m_run && t && m_cnt != 16'd0) m_cnt = m_cnt - 16'd1;
    if (w && a == 2'd1) m_ien = d[1];
    m_run  = setr ? 1'b1 : (uf ? 1'b0 : m_run);
    m_done = clr ? 1'b0 : (uf ? 1'b1 : m_done);
    @(negedge clk);
    chk({tag, " rdata"}, rdata, e_rdata);
    chk({tag, " pulse"}, {15'd0, pulse_out}, {15'd0, m_run});
    chk({tag, " irq"},   {15'd0, irq}, {15'd0, m_done & m_ien});
  endtask

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R9 reset state
    chk("R9 rdata", rdata, 16'd0);
    chk("R9 pulse", {15'd0, pulse_out}, 16'd0);
    chk("R9 irq",   {15'd0, irq}, 16'd0);
    step(0, 0, 2'd0, 0, "R9");
    step(0, 0, 2'd1, 0, "R9");
    // R1 write, read back, ticks without run leave count alone
    step(0, 1, 2'd0, 16'd5, "R1");
    step(1, 0, 2'd0, 0, "R1");
    step(1, 0, 2'd0, 0, "R1");
    // R11 unused address reads zero
    step(0, 0, 2'd3, 0, "R11");
    step(0, 0, 2'd3, 0, "R11");
    // R8 enable only, no interrupt yet
    step(0, 1, 2'd1, 16'd2, "R8");
    // R7 start, pulse rises
    step(0, 1, 2'd1, 16'd3, "R7");
    step(1, 0, 2'd0, 0, "R1");
    step(1, 0, 2'd0, 0, "R1");
    // R3 write against tick
    step(1, 1, 2'd0, 16'd9, "R3");
    step(0, 0, 2'd0, 0, "R3");
    // R2 writing zero to run bit is ignored
    step(0, 1, 2'd1, 16'd2, "R2");
    step(0, 0, 2'd1, 0, "R2");
    // R5 halt by zero load, effective at next tick
    step(0, 1, 2'd0, 16'd0, "R5");
    step(0, 0, 2'd0, 0, "R5");
    step(0, 0, 2'd0, 0, "R5");
    step(1, 0, 2'd2, 0, "R5");
    step(0, 0, 2'd2, 0, "R4");
    // R6 write zero no effect, write one clears
    step(0, 1, 2'd2, 16'd0, "R6");
    step(0, 1, 2'd2, 16'd1, "R6");
    step(0, 0, 2'd2, 0, "R6");
    // R6 clear against underflow
    step(0, 1, 2'd1, 16'd3, "R6");
    step(1, 1, 2'd2, 16'd1, "R6");
    step(0, 0, 2'd2, 0, "R6");
    // R10 set against underflow restarts
    step(0, 1, 2'd1, 16'd3, "R10");
    step(1, 1, 2'd1, 16'd3, "R10");
    step(0, 0, 2'd2, 0, "R10");
    // R4 natural run to underflow from 2
    step(0, 1, 2'd0, 16'd2, "R4");
    repeat (3) step(1, 0, 2'd0, 0, "R4");
    step(0, 0, 2'd0, 0, "R4");
    // constrained random mix
    for (int i = 0; i < 4000; i++) begin
      logic t, w;
      logic [1:0] a;
      logic [15:0] d;
      t = ($urandom % 3) == 0;
      w = ($urandom % 6) == 0;
      a = 2'($urandom);
      d = (a == 2'd0) ? 16'($urandom % 6) : 16'($urandom);
      if (($urandom % 50) == 0) d = 16'hFFFF;
      step(t, w, a, d, "R1 R4 R7 R8 rand");
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule